// File: doc/BRIEF.md
# Watchdog with Programmable Reset Pulse

This block supervises software by timing the interval between service strobes. A counter starts at zero and advances once per millisecond tick. A high-to-low transition on the active-low kick input clears it. If the counter reaches the selected watchdog period, the block pulls its active-low reset output low for a selectable pulse width. When the pulse ends, the output returns high and the counter starts again from zero.

The kick input passes through a two-flop synchronizer, and only a falling edge of the synchronized signal services the timer. A kick held permanently low therefore never services the watchdog, and the block produces a steady train of reset pulses. Kick edges that arrive while a reset pulse is active are ignored. Both selections arrive on static input ports. The period select has one code that turns the watchdog off.

Top module: `wdt_rstpulse`

## Requirements
- R1: While `rst_n` is low, `wdt_rst_n_o` is high, and it stays high after release until the first timeout.
- R2: With no kick edge, `wdt_rst_n_o` falls on the clock edge that carries the P-th tick since timing began. P is PERIOD_BASE for `period_sel_i`=01, 4×PERIOD_BASE for 10 and 16×PERIOD_BASE for 11 (defaults 100, 400 and 1600 ms).
- R3: `period_sel_i`=00 disables the watchdog, and `wdt_rst_n_o` stays high whatever the kick input does.
- R4: A reset pulse lasts exactly L ticks, with L = PULSE_BASE shifted left by `pulse_sel_i`. That gives 1, 2, 4 and 8 times the base for 00, 01, 10 and 11, which is 25, 50, 100 and 200 ms by default.
- R5: At the end of a pulse the counter restarts from zero, so without a kick the next timeout follows exactly P ticks after the rising edge.
- R6: A falling edge on `kick_n_i` clears the count. A low level first sampled at clock edge k clears the count at edge k+2, and the timeout then follows P ticks later.
- R7: A kick held low gives no service, and the output repeats L ticks low followed by P ticks high indefinitely.
- R8: A falling kick edge during a reset pulse neither shortens nor lengthens the pulse, and it does not shift the next timeout.
- R9: The output changes only on clock edges where `tick_i` is high. Clock edges without a tick advance nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle enable per millisecond of timing |
| kick_n_i | input | 1 | Active-low service strobe, asynchronous |
| period_sel_i | input | 2 | Watchdog period select, 00 disables |
| pulse_sel_i | input | 2 | Reset pulse width select |
| wdt_rst_n_o | output | 1 | Active-low reset pulse output |

## Verification
The checker assumes that both select inputs stay constant while timing runs. Its pulse-width properties compute the expected width from the current `pulse_sel_i`, and the off-code property assumes the period select does not leave 00 on its own. The bench changes a select only while `rst_n` is low, between cases. It drives the tick and the kick only at the falling clock edge, so each stimulus cycle is known and the counted ticks and cycles match the requirement arithmetic. Ticks come either every cycle or every third cycle, which keeps R9 inside the assumption that ticks are single-cycle enables.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_PULSE = 1'b1
    } wdt_state_e;

    localparam logic [1:0] PERIOD_OFF = 2'b00;

endpackage

// File: rtl/wdt_kick_sync.sv
`timescale 1ns/1ps
module wdt_kick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_n_i,
    output logic fall_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] sync_d, sync_q;
    logic              prev_d, prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sync_d = kick_n_i;
        end else begin : g_chain
            always_comb sync_d = {sync_q[STAGES-2:0], kick_n_i};
        end
    endgenerate

    always_comb prev_d = sync_q[LAST];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assign fall_o = prev_q & ~sync_q[LAST];
endmodule

// File: rtl/wdt_limit_dec.sv
`timescale 1ns/1ps
module wdt_limit_dec #(
    parameter int PERIOD_BASE = 100,
    parameter int PULSE_BASE  = 25,
    parameter int CNT_W       = 11
) (
    input  logic [1:0]       period_sel_i,
    input  logic [1:0]       pulse_sel_i,
    output logic             enable_o,
    output logic [CNT_W-1:0] period_lim_o,
    output logic [CNT_W-1:0] pulse_lim_o
);
    import wdt_pkg::*;

    always_comb begin
        enable_o = (period_sel_i != PERIOD_OFF);
        unique case (period_sel_i)
            2'b01:   period_lim_o = CNT_W'(PERIOD_BASE);
            2'b10:   period_lim_o = CNT_W'(PERIOD_BASE * 4);
            2'b11:   period_lim_o = CNT_W'(PERIOD_BASE * 16);
            default: period_lim_o = '0;
        endcase
        pulse_lim_o = CNT_W'(PULSE_BASE) << pulse_sel_i;
    end
endmodule

// File: rtl/wdt_timer_core.sv
`timescale 1ns/1ps
module wdt_timer_core #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             fall_i,
    input  logic             enable_i,
    input  logic [CNT_W-1:0] period_lim_i,
    input  logic [CNT_W-1:0] pulse_lim_i,
    output logic             rst_n_o
);
    import wdt_pkg::*;

    typedef struct packed {
        wdt_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             out_n;
    } core_s;

    localparam core_s CORE_RST = '{st: ST_RUN, cnt: '0, out_n: 1'b1};

    core_s            core_d, core_q;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        core_d  = core_q;
        cnt_inc = core_q.cnt + 1'b1;
        unique case (core_q.st)
            ST_RUN: begin
                if (!enable_i || fall_i) begin
                    core_d.cnt = '0;
                end else if (tick_i) begin
                    if (cnt_inc >= period_lim_i) begin
                        core_d.st    = ST_PULSE;
                        core_d.cnt   = '0;
                        core_d.out_n = 1'b0;
                    end else begin
                        core_d.cnt = cnt_inc;
                    end
                end
            end
            ST_PULSE: begin
                if (tick_i) begin
                    if (cnt_inc >= pulse_lim_i) begin
                        core_d.st    = ST_RUN;
                        core_d.cnt   = '0;
                        core_d.out_n = 1'b1;
                    end else begin
                        core_d.cnt = cnt_inc;
                    end
                end
            end
            default: core_d = CORE_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= CORE_RST;
        else        core_q <= core_d;
    end

    assign rst_n_o = core_q.out_n;
endmodule

// File: rtl/wdt_rstpulse.sv
`timescale 1ns/1ps
module wdt_rstpulse #(
    parameter int PERIOD_BASE = 100,
    parameter int PULSE_BASE  = 25,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       kick_n_i,
    input  logic [1:0] period_sel_i,
    input  logic [1:0] pulse_sel_i,
    output logic       wdt_rst_n_o
);
    localparam int MAX_PERIOD = PERIOD_BASE * 16;
    localparam int MAX_PULSE  = PULSE_BASE * 8;
    localparam int MAX_LIM    = (MAX_PERIOD > MAX_PULSE) ? MAX_PERIOD : MAX_PULSE;
    localparam int CNT_W      = $clog2(MAX_LIM + 1);

    logic             kick_fall;
    logic             wd_enable;
    logic [CNT_W-1:0] period_lim;
    logic [CNT_W-1:0] pulse_lim;

    wdt_kick_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .kick_n_i (kick_n_i),
        .fall_o   (kick_fall)
    );

    wdt_limit_dec #(
        .PERIOD_BASE (PERIOD_BASE),
        .PULSE_BASE  (PULSE_BASE),
        .CNT_W       (CNT_W)
    ) dec_i (
        .period_sel_i (period_sel_i),
        .pulse_sel_i  (pulse_sel_i),
        .enable_o     (wd_enable),
        .period_lim_o (period_lim),
        .pulse_lim_o  (pulse_lim)
    );

    wdt_timer_core #(.CNT_W(CNT_W)) core_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .fall_i       (kick_fall),
        .enable_i     (wd_enable),
        .period_lim_i (period_lim),
        .pulse_lim_i  (pulse_lim),
        .rst_n_o      (wdt_rst_n_o)
    );
endmodule

// File: rtl/wdt_rstpulse_chk.sv
`timescale 1ns/1ps
module wdt_rstpulse_chk #(
    parameter int PULSE_BASE = 25
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_i,
    input logic [1:0] period_sel_i,
    input logic [1:0] pulse_sel_i,
    input logic       wdt_rst_n_o
);
    logic [15:0] low_ticks_q;
    logic [15:0] low_next;
    logic [15:0] pulse_exp;

    always_comb begin
        low_next  = low_ticks_q + 16'(tick_i);
        pulse_exp = 16'(PULSE_BASE) << pulse_sel_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           low_ticks_q <= '0;
        else if (wdt_rst_n_o) low_ticks_q <= '0;
        else                  low_ticks_q <= low_next;
    end

    // R1: output held inactive while reset is applied
    p_reset_high_r1: assert property (@(posedge clk)
        !rst_n |=> wdt_rst_n_o);

    // R3: off code never produces a pulse
    p_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (period_sel_i == 2'b00 && wdt_rst_n_o) |=> wdt_rst_n_o);

    // R4: pulse ends on the tick that completes the selected width
    p_pulse_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wdt_rst_n_o && low_next == pulse_exp) |=> wdt_rst_n_o);

    // R8: pulse is held until its width completes, kicks notwithstanding
    p_pulse_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wdt_rst_n_o && low_next < pulse_exp) |=> !wdt_rst_n_o);

    // R9: no tick, no output change
    p_tick_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(wdt_rst_n_o));
endmodule

bind wdt_rstpulse wdt_rstpulse_chk #(.PULSE_BASE(PULSE_BASE)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .period_sel_i (period_sel_i),
    .pulse_sel_i  (pulse_sel_i),
    .wdt_rst_n_o  (wdt_rst_n_o)
);

// File: tb/wdt_rstpulse_tb_top.sv
`timescale 1ns/1ps
module wdt_rstpulse_tb_top;
    localparam int PB = 5;
    localparam int LB = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       kick_n = 1'b1;
    logic [1:0] psel = 2'b01;
    logic [1:0] lsel = 2'b00;
    logic       rst_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    wdt_rstpulse #(.PERIOD_BASE(PB), .PULSE_BASE(LB)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick),
        .kick_n_i     (kick_n),
        .period_sel_i (psel),
        .pulse_sel_i  (lsel),
        .wdt_rst_n_o  (rst_out)
    );

    function automatic int exp_period(input logic [1:0] s);
        case (s)
            2'b01:   return PB;
            2'b10:   return PB * 4;
            2'b11:   return PB * 16;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_pulse(input logic [1:0] s);
        return LB << s;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] ps, input logic [1:0] ls);
        rst_n  = 1'b0;
        kick_n = 1'b1;
        tick   = 1'b0;
        psel   = ps;
        lsel   = ls;
        repeat (3) @(negedge clk);
        check(rst_out == 1'b1, "R1", int'(rst_out), 1);
        rst_n = 1'b1;
    endtask

    // Runs from a falling clock edge until the output equals want.
    task automatic measure(input bit want, input int div, input int fall_at,
                           input bit hold, output int ticks, output int cycles);
        ticks  = 0;
        cycles = 0;
        for (int i = 0; i < 6000; i++) begin
            tick = ((i % div) == 0);
            if (i == fall_at) kick_n = 1'b0;
            if (!hold && fall_at >= 0 && i == fall_at + 4) kick_n = 1'b1;
            @(posedge clk);
            if (tick) ticks++;
            cycles++;
            @(negedge clk);
            if (rst_out == want) break;
        end
    endtask

    initial begin
        #1_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int t, c, lows;
        @(negedge clk);

        // R2, R4, R5, R9: sweep of all enabled periods and all pulse widths
        for (int ps = 1; ps < 4; ps++) begin
            for (int ls = 0; ls < 4; ls++) begin
                int div;
                div = (ls == 2) ? 3 : 1;
                do_reset(2'(ps), 2'(ls));
                measure(1'b0, div, -1, 1'b0, t, c);
                check(t == exp_period(2'(ps)), "R2", t, exp_period(2'(ps)));
                if (div == 3)
                    check(c == 3 * exp_period(2'(ps)) - 2, "R9", c, 3 * exp_period(2'(ps)) - 2);
                measure(1'b1, div, -1, 1'b0, t, c);
                check(t == exp_pulse(2'(ls)), "R4", t, exp_pulse(2'(ls)));
                measure(1'b0, div, -1, 1'b0, t, c);
                check(t == exp_period(2'(ps)), "R5", t, exp_period(2'(ps)));
            end
        end

        // R3: off code with kick activity
        do_reset(2'b00, 2'b00);
        lows = 0;
        for (int i = 0; i < 400; i++) begin
            tick   = 1'b1;
            kick_n = ((i % 37) < 20);
            @(posedge clk);
            @(negedge clk);
            if (!rst_out) lows++;
        end
        check(lows == 0, "R3", lows, 0);

        // R6: kick at iteration 5 clears count at edge 8, timeout P later
        do_reset(2'b10, 2'b00);
        measure(1'b0, 1, 5, 1'b0, t, c);
        check(c == 5 + 3 + exp_period(2'b10), "R6", c, 5 + 3 + exp_period(2'b10));

        // R7: kick held low gives a repeating pulse train
        do_reset(2'b01, 2'b01);
        measure(1'b0, 1, 0, 1'b1, t, c);
        check(c == 3 + exp_period(2'b01), "R7", c, 3 + exp_period(2'b01));
        for (int k = 0; k < 2; k++) begin
            measure(1'b1, 1, -1, 1'b0, t, c);
            check(t == exp_pulse(2'b01), "R7", t, exp_pulse(2'b01));
            measure(1'b0, 1, -1, 1'b0, t, c);
            check(t == exp_period(2'b01), "R7", t, exp_period(2'b01));
        end

        // R8: kick edge inside a pulse is ignored
        do_reset(2'b10, 2'b11);
        measure(1'b0, 1, -1, 1'b0, t, c);
        check(t == exp_period(2'b10), "R2", t, exp_period(2'b10));
        measure(1'b1, 1, 2, 1'b0, t, c);
        check(t == exp_pulse(2'b11), "R8", t, exp_pulse(2'b11));
        measure(1'b0, 1, -1, 1'b0, t, c);
        check(t == exp_period(2'b10), "R8", t, exp_period(2'b10));

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule